// File: doc/BRIEF.md
# Multi-Lane Half-Duplex Serial Shifter

This block is the data engine of a serial master that moves a word over one, two or four data lanes. In single-lane mode it behaves as a classic full-duplex shifter: lane 0 carries outgoing bits and lane 1 carries incoming bits, one of each per serial clock. In dual and quad modes the lanes are bidirectional and the transfer is half-duplex. For a whole transfer every active lane either drives or listens, so two or four bits move per serial clock in one direction.

A transfer is requested with a one-cycle `start` plus a lane mode, a direction, a bit count and a right-aligned transmit word. The block then lowers the select, generates the serial clock (idle low, data launched on the falling edge, sampled on the rising edge) and sends the most significant bit first. When the last group has been clocked, it returns the received word right-aligned and pulses `done`. A fixed idle gap follows every transfer, so a lane that is turned around is never driven by both ends at once. Tristate buffers sit outside the block and are controlled by the per-lane output enables.

Top module: `spi_ml_shifter`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sd_oe` is 0, `busy` and `done` are 0 and `rx_word` is 0.
- R2: A `start` seen at a clock edge while `busy` is 0, with valid settings, lowers `cs_n` from the next cycle. Each bit group then takes HALF cycles with `sclk` low followed by HALF cycles with `sclk` high. `sclk` is 0 whenever `cs_n` is 1.
- R3: `lane_mode` encodes 0 = single lane, 1 = dual, 2 = quad. The value 3 is reserved, and a `start` carrying it is ignored.
- R4: Bits `bit_cnt-1` down to 0 of `tx_word` are sent most significant bit first. In quad mode `sd_o[3]` carries the highest bit of each nibble and `sd_o[0]` the lowest. In dual mode `sd_o[1]` carries the higher bit of each pair. In single mode the bits leave on `sd_o[0]`.
- R5: In single mode `dir_rx` is ignored, `sd_oe` is 4'b0001 while selected, and one bit per clock is taken from `sd_i[1]`. After the transfer `rx_word` holds the `bit_cnt` received bits right-aligned, with the first bit received in the highest position.
- R6: In dual or quad mode with `dir_rx` = 1, `sd_oe` stays 0 for the whole transfer. The active lanes are sampled on each rising `sclk` with the same lane order as R4, and the result is returned in `rx_word` as in R5.
- R7: In dual or quad mode with `dir_rx` = 0, the active lanes are enabled (4'b0011 or 4'b1111) while selected, and `rx_word` keeps its previous value.
- R8: A `start` whose `bit_cnt` is zero, larger than W, or not a multiple of the lane count is ignored and `busy` stays 0.
- R9: `done` is high for exactly one cycle. It comes in the first cycle after the last high phase of `sclk`, in the same cycle that `cs_n` returns to 1 and `rx_word` takes its new value.
- R10: `busy` is 1 from the cycle after acceptance until GAP_CYC cycles with `cs_n` high have passed, counting the `done` cycle. Any `start` while `busy` is 1 is ignored.
- R11: Mode, direction, count and transmit word are captured when the transfer is accepted. Later changes to those inputs have no effect on the transfer, and `sd_o` stays stable while `sclk` is high.
- R12: `sd_o` is 0 on every lane whose `sd_oe` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Transfer request, taken when idle |
| lane_mode | input | 2 | 0 single, 1 dual, 2 quad, 3 reserved |
| dir_rx | input | 1 | 1 = multi-lane receive, 0 = multi-lane transmit |
| bit_cnt | input | $clog2(W+1) | Number of bits in the transfer |
| tx_word | input | W | Right-aligned word to send |
| sd_i | input | 4 | Lane input values |
| busy | output | 1 | Transfer or idle gap in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | W | Right-aligned received word |
| cs_n | output | 1 | Select, active low |
| sclk | output | 1 | Serial clock, idle low |
| sd_o | output | 4 | Lane output values |
| sd_oe | output | 4 | Per-lane output enables |

## Verification
The bench builds the block with W = 16, HALF = 1 and GAP_CYC = 2. With 16 bits, a quad transfer of four nibbles, dual transfers of odd pair counts and single-lane words of odd length all fit. A two-cycle gap makes the back-to-back and held-start cases show that a request is ignored through the whole turnaround, not only during the `done` cycle. HALF = 1 lets the bench's slave model present one new lane group in every low phase of `sclk`.

// File: rtl/spi_ml_pkg.sv
package spi_ml_pkg;

   typedef enum logic [1:0] {
      LM_SINGLE = 2'd0,
      LM_DUAL   = 2'd1,
      LM_QUAD   = 2'd2,
      LM_RSVD   = 2'd3
   } lane_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

   // log2 of the number of bits moved per serial clock
   function automatic logic [1:0] lane_shamt(lane_mode_e m);
      case (m)
         LM_DUAL: lane_shamt = 2'd1;
         LM_QUAD: lane_shamt = 2'd2;
         default: lane_shamt = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/spi_ml_sclk.sv
module spi_ml_sclk #(
   parameter int HALF = 1,
   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_p,
   output logic fall_p
);

   logic [HW-1:0] half_cnt;
   logic          half_end;

   assign half_end = (half_cnt == HW'(HALF - 1));
   assign rise_p   = run && !sclk && half_end;
   assign fall_p   = run &&  sclk && half_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         sclk     <= 1'b0;
      end else if (!run) begin
         half_cnt <= '0;
         sclk     <= 1'b0;
      end else if (half_end) begin
         half_cnt <= '0;
         sclk     <= ~sclk;
      end else begin
         half_cnt <= half_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/spi_ml_tx.sv
module spi_ml_tx
   import spi_ml_pkg::*;
#(
   parameter int W = 16,
   localparam int CNT_W = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic [W-1:0]     load_word,
   input  logic             shift,
   input  lane_mode_e       mode,
   output logic [3:0]       grp
);

   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (load) begin
         sh <= load_word << (CNT_W'(W) - load_cnt);
      end else if (shift) begin
         case (mode)
            LM_QUAD: sh <= sh << 4;
            LM_DUAL: sh <= sh << 2;
            default: sh <= sh << 1;
         endcase
      end
   end

   // lane i takes its bit from the top of the left-aligned register
   for (genvar i = 0; i < 4; i++) begin : g_lane
      if (i == 0) begin : g_l0
         assign grp[i] = (mode == LM_QUAD) ? sh[W-4] :
                         (mode == LM_DUAL) ? sh[W-2] : sh[W-1];
      end else if (i == 1) begin : g_l1
         assign grp[i] = (mode == LM_QUAD) ? sh[W-3] :
                         (mode == LM_DUAL) ? sh[W-1] : 1'b0;
      end else begin : g_lhi
         assign grp[i] = (mode == LM_QUAD) ? sh[W-4+i] : 1'b0;
      end
   end

endmodule

// File: rtl/spi_ml_rx.sv
module spi_ml_rx
   import spi_ml_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         sample,
   input  logic         capture,
   input  lane_mode_e   mode,
   input  logic [3:0]   sd_i,
   output logic [W-1:0] rx_word
);

   logic [W-1:0] rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsh <= '0;
      end else if (clr) begin
         rsh <= '0;
      end else if (sample) begin
         case (mode)
            LM_QUAD: rsh <= {rsh[W-5:0], sd_i};
            LM_DUAL: rsh <= {rsh[W-3:0], sd_i[1:0]};
            default: rsh <= {rsh[W-2:0], sd_i[1]};
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word <= '0;
      end else if (capture) begin
         rx_word <= rsh;
      end
   end

endmodule

// File: rtl/spi_ml_shifter.sv
module spi_ml_shifter
   import spi_ml_pkg::*;
#(
   parameter int W       = 16,
   parameter int HALF    = 1,
   parameter int GAP_CYC = 1,
   localparam int CNT_W  = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       lane_mode,
   input  logic             dir_rx,
   input  logic [CNT_W-1:0] bit_cnt,
   input  logic [W-1:0]     tx_word,
   input  logic [3:0]       sd_i,
   output logic             busy,
   output logic             done,
   output logic [W-1:0]     rx_word,
   output logic             cs_n,
   output logic             sclk,
   output logic [3:0]       sd_o,
   output logic [3:0]       sd_oe
);

   localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

   if (W < 4 || (W % 4) != 0) begin : g_bad_w
      $error("spi_ml_shifter: W must be a multiple of 4 and at least 4");
   end
   if (HALF < 1) begin : g_bad_half
      $error("spi_ml_shifter: HALF must be at least 1");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("spi_ml_shifter: GAP_CYC must be at least 1");
   end

   seq_state_e       state;
   lane_mode_e       mode_in, mode_q;
   logic             dir_q;
   logic [CNT_W-1:0] grp_left;
   logic [GAP_W-1:0] gap_cnt;
   logic             done_q;
   logic             mult_ok, cnt_ok, req_ok, go, run;
   logic             sclk_w, rise_p, fall_p, last_fall, shift_en, cap_en;
   logic [3:0]       grp, oe_w;

   // request validation
   always_comb begin
      mode_in = lane_mode_e'(lane_mode);
      case (mode_in)
         LM_SINGLE: mult_ok = 1'b1;
         LM_DUAL:   mult_ok = !bit_cnt[0];
         LM_QUAD:   mult_ok = (bit_cnt[1:0] == 2'b00);
         default:   mult_ok = 1'b0;
      endcase
   end

   assign cnt_ok = (bit_cnt != '0) && (bit_cnt <= CNT_W'(W));
   assign req_ok = mult_ok && cnt_ok;
   assign go     = (state == ST_IDLE) && start && req_ok;
   assign run    = (state == ST_RUN);

   assign last_fall = run && fall_p && (grp_left == CNT_W'(1));
   assign shift_en  = run && fall_p && (grp_left != CNT_W'(1));
   assign cap_en    = last_fall && ((mode_q == LM_SINGLE) || dir_q);

   // transfer sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode_q   <= LM_SINGLE;
         dir_q    <= 1'b0;
         grp_left <= '0;
         gap_cnt  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (go) begin
                  state    <= ST_RUN;
                  mode_q   <= mode_in;
                  dir_q    <= dir_rx;
                  grp_left <= bit_cnt >> lane_shamt(mode_in);
               end
            end
            ST_RUN: begin
               if (last_fall) begin
                  state   <= ST_GAP;
                  done_q  <= 1'b1;
                  gap_cnt <= GAP_W'(GAP_CYC - 1);
               end else if (shift_en) begin
                  grp_left <= grp_left - 1'b1;
               end
            end
            ST_GAP: begin
               if (gap_cnt == '0) state <= ST_IDLE;
               else               gap_cnt <= gap_cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // lane drive enables
   always_comb begin
      oe_w = 4'b0000;
      if (run) begin
         case (mode_q)
            LM_SINGLE: oe_w = 4'b0001;
            LM_DUAL:   oe_w = dir_q ? 4'b0000 : 4'b0011;
            LM_QUAD:   oe_w = dir_q ? 4'b0000 : 4'b1111;
            default:   oe_w = 4'b0000;
         endcase
      end
   end

   spi_ml_sclk #(.HALF(HALF)) u_sclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .sclk   (sclk_w),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   spi_ml_tx #(.W(W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (go),
      .load_cnt  (bit_cnt),
      .load_word (tx_word),
      .shift     (shift_en),
      .mode      (mode_q),
      .grp       (grp)
   );

   spi_ml_rx #(.W(W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (go),
      .sample  (rise_p),
      .capture (cap_en),
      .mode    (mode_q),
      .sd_i    (sd_i),
      .rx_word (rx_word)
   );

   assign busy  = (state != ST_IDLE);
   assign done  = done_q;
   assign cs_n  = !run;
   assign sclk  = sclk_w;
   assign sd_oe = oe_w;
   assign sd_o  = grp & oe_w;

   // accepted request selects with the serial clock low
   p_start_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && req_ok) |=> (!cs_n && !sclk));

   // serial clock rests low while deselected
   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // multi-lane receive never drives a lane
   p_rx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && dir_q && (mode_q != LM_SINGLE)) |-> (sd_oe == 4'b0000));

   // multi-lane transmit leaves the received word alone
   p_rx_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !dir_q && (mode_q != LM_SINGLE)) |-> $stable(rx_word));

   // malformed requests do not start anything
   p_bad_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !req_ok) |=> !busy);

   // done is one cycle wide and comes with select released
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);

   // lane data holds through the high phase
   p_hold_sd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sclk) |-> $stable(sd_o));

   // nothing driven on a disabled lane
   p_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((sd_o & ~sd_oe) == 4'b0000));

endmodule

// File: tb/spi_ml_shifter_tb.sv
`timescale 1ns/1ps
module spi_ml_shifter_tb;

   localparam int W     = 16;
   localparam int HALF  = 1;   // slave model below assumes one-cycle phases
   localparam int GAP   = 2;
   localparam int CNT_W = $clog2(W + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       lane_mode = 2'd0;
   logic             dir_rx = 1'b0;
   logic [CNT_W-1:0] bit_cnt = '0;
   logic [W-1:0]     tx_word = '0;
   logic [3:0]       sd_i = 4'h0;
   logic             busy, done, cs_n, sclk;
   logic [W-1:0]     rx_word;
   logic [3:0]       sd_o, sd_oe;

   always #2 clk = ~clk;

   spi_ml_shifter #(.W(W), .HALF(HALF), .GAP_CYC(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .lane_mode(lane_mode),
      .dir_rx(dir_rx), .bit_cnt(bit_cnt), .tx_word(tx_word), .sd_i(sd_i),
      .busy(busy), .done(done), .rx_word(rx_word), .cs_n(cs_n),
      .sclk(sclk), .sd_o(sd_o), .sd_oe(sd_oe)
   );

   typedef struct packed {
      logic         cs_n;
      logic         sclk;
      logic         busy;
      logic         done;
      logic [3:0]   oe;
      logic [3:0]   o;
      logic [W-1:0] rx;
   } exp_t;

   exp_t         q[$];
   logic [W-1:0] cur_rx = '0;
   int           errors = 0;
   int           checks = 0;
   bit           finished = 0;

   // requested stimulus
   logic         s_start = 0;
   int           s_mode = 0;
   logic         s_dir = 0;
   int           s_cnt = 0;
   logic [W-1:0] s_tx = '0;
   logic [W-1:0] s_src = '0;

   // parameters of the transfer in flight, for the slave model
   int           t_mode = 0;
   int           t_cnt = 0;
   int           t_lanes = 1;
   logic [W-1:0] t_src = '0;
   int           gidx = 0;
   int           done_seen = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int lanes_of(int m);
      case (m)
         0: return 1;
         1: return 2;
         2: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic bit req_valid(int m, int c);
      int l = lanes_of(m);
      return (l != 0) && (c >= 1) && (c <= W) && ((c % l) == 0);
   endfunction

   task automatic push_transfer();
      exp_t e;
      int l = lanes_of(s_mode);
      int n = s_cnt / l;
      logic [3:0] oe_e;
      logic [W-1:0] new_rx;
      bit cap = (s_mode == 0) || s_dir;
      if (s_mode == 0) oe_e = 4'b0001;
      else if (s_dir)  oe_e = 4'b0000;
      else if (s_mode == 1) oe_e = 4'b0011;
      else oe_e = 4'b1111;
      new_rx = cap ? (s_src & W'((32'h1 << s_cnt) - 1)) : cur_rx;
      for (int k = 0; k < n; k++) begin
         logic [3:0] o = 4'b0000;
         for (int i = 0; i < 4; i++) begin
            if (oe_e[i]) begin
               int li = (s_mode == 0) ? 0 : i;
               o[i] = s_tx[s_cnt - 1 - k*l - (l - 1 - li)];
            end
         end
         e = '{cs_n:1'b0, sclk:1'b0, busy:1'b1, done:1'b0, oe:oe_e, o:o, rx:cur_rx};
         q.push_back(e);
         e.sclk = 1'b1;
         q.push_back(e);
      end
      for (int g = 0; g < GAP; g++) begin
         e = '{cs_n:1'b1, sclk:1'b0, busy:1'b1, done:(g == 0), oe:4'b0, o:4'b0, rx:new_rx};
         q.push_back(e);
      end
      t_mode = s_mode; t_cnt = s_cnt; t_lanes = l; t_src = s_src; gidx = 0;
   endtask

   // one clock: compare against the model, answer as slave, apply stimulus
   task automatic step();
      exp_t e;
      bit was_empty;
      @(negedge clk);
      was_empty = (q.size() == 0);
      if (was_empty) e = '{cs_n:1'b1, sclk:1'b0, busy:1'b0, done:1'b0, oe:4'b0, o:4'b0, rx:cur_rx};
      else begin
         e = q.pop_front();
         cur_rx = e.rx;
      end
      chk("R2", "cs_n", 32'(cs_n), 32'(e.cs_n));
      chk("R2", "sclk", 32'(sclk), 32'(e.sclk));
      chk("R10", "busy", 32'(busy), 32'(e.busy));
      chk("R9", "done", 32'(done), 32'(e.done));
      chk("R5/R6/R7", "sd_oe", 32'(sd_oe), 32'(e.oe));
      chk("R4/R12", "sd_o", 32'(sd_o), 32'(e.o));
      chk("R5/R6", "rx_word", 32'(rx_word), 32'(e.rx));
      if (done === 1'b1) done_seen++;
      // slave: present the next group during each low phase
      if (cs_n === 1'b0 && sclk === 1'b0) begin
         logic [3:0] v = 4'($urandom);
         if (gidx * t_lanes < t_cnt) begin
            if (t_mode == 0) v[1] = t_src[t_cnt - 1 - gidx];
            else for (int j = 0; j < t_lanes; j++)
               v[j] = t_src[t_cnt - 1 - gidx*t_lanes - (t_lanes - 1 - j)];
         end
         sd_i = v;
         gidx++;
      end
      start     = s_start;
      lane_mode = 2'(s_mode);
      dir_rx    = s_dir;
      bit_cnt   = CNT_W'(s_cnt);
      tx_word   = s_tx;
      if (s_start && was_empty && req_valid(s_mode, s_cnt)) push_transfer();
   endtask

   task automatic drain();
      while (q.size() > 0) step();
      step();
   endtask

   task automatic xfer(int m, logic d, int c, logic [W-1:0] tx, logic [W-1:0] src);
      s_mode = m; s_dir = d; s_cnt = c; s_tx = tx; s_src = src; s_start = 1;
      step();
      s_start = 0;
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk("R1", "cs_n", 32'(cs_n), 32'd1);
      chk("R1", "sclk", 32'(sclk), 32'd0);
      chk("R1", "sd_oe", 32'(sd_oe), 32'd0);
      chk("R1", "busy", 32'(busy), 32'd0);
      chk("R1", "done", 32'(done), 32'd0);
      chk("R1", "rx_word", 32'(rx_word), 32'd0);

      // R4 R7: quad transmit, nibble order on sd3..sd0
      xfer(2, 1'b0, 16, 16'hA5C3, 16'h1234);
      chk("R7", "rx after quad tx", 32'(rx_word), 32'd0);
      // R6: quad receive
      xfer(2, 1'b1, 16, 16'hFFFF, 16'h3C96);
      chk("R6", "quad rx word", 32'(rx_word), 32'h3C96);
      // R4 R7: dual transmit, 10 bits
      xfer(1, 1'b0, 10, 16'h02D9, 16'hBEEF);
      chk("R7", "rx after dual tx", 32'(rx_word), 32'h3C96);
      // R6: dual receive, 6 bits
      xfer(1, 1'b1, 6, 16'h0000, 16'hFF2B);
      chk("R6", "dual rx word", 32'(rx_word), 32'h002B);
      // R5: single lane, odd length, direction ignored
      xfer(0, 1'b1, 7, 16'h0055, 16'h004E);
      chk("R5", "single rx word", 32'(rx_word), 32'h004E);
      xfer(0, 1'b0, 16, 16'h8001, 16'h6A5F);
      chk("R5", "single rx 16", 32'(rx_word), 32'h6A5F);
      // quad receive of a single nibble
      xfer(2, 1'b1, 4, 16'h0000, 16'h000B);
      chk("R6", "quad rx nibble", 32'(rx_word), 32'h000B);

      // R3: reserved lane code ignored
      xfer(3, 1'b0, 8, 16'h00FF, 16'h0000);
      chk("R3", "busy after reserved mode", 32'(busy), 32'd0);
      // R8: malformed counts ignored
      xfer(2, 1'b0, 6, 16'h003F, 16'h0000);
      chk("R8", "busy after quad count 6", 32'(busy), 32'd0);
      xfer(1, 1'b1, 5, 16'h001F, 16'h0000);
      chk("R8", "busy after dual count 5", 32'(busy), 32'd0);
      xfer(0, 1'b0, 0, 16'h0001, 16'h0000);
      chk("R8", "busy after count 0", 32'(busy), 32'd0);
      xfer(0, 1'b0, 20, 16'h0001, 16'h0000);
      chk("R8", "busy after count above W", 32'(busy), 32'd0);
      chk("R8", "rx kept", 32'(rx_word), 32'h000B);

      // R10: start held high; turnaround gap between transfers
      done_seen = 0;
      s_mode = 2; s_dir = 1'b0; s_cnt = 4; s_tx = 16'h0009; s_src = 16'h0; s_start = 1;
      repeat (10) step();
      s_start = 0;
      drain();
      chk("R10", "transfers from held start", 32'(done_seen), 32'd2);
      // R10: direction flip right after a transfer
      xfer(1, 1'b1, 4, 16'h0, 16'h000E);
      xfer(1, 1'b0, 4, 16'h0006, 16'h0);
      chk("R10", "rx after turnaround", 32'(rx_word), 32'h000E);

      // R11: inputs changed and start pulsed during a transfer
      s_mode = 2; s_dir = 1'b1; s_cnt = 12; s_tx = 16'h0; s_src = 16'h0ACE; s_start = 1;
      step();
      for (int k = 0; k < 6; k++) begin
         s_mode = k % 4; s_dir = k[0]; s_cnt = 4 + k; s_tx = 16'($urandom);
         s_start = (k % 2 == 0);
         step();
      end
      s_start = 0;
      while (q.size() > 0) step();
      s_mode = 0; s_cnt = 0;
      step();
      chk("R11", "rx after mid-transfer changes", 32'(rx_word), 32'h0ACE);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R10 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule